// File: doc/BRIEF.md
# Privilege-Filtered Performance Counter with Sticky Overflow

This block is one hardware performance counter paired with its control register. Every clock it receives a one-cycle event pulse and the hart's current privilege mode. It adds one to the counter unless the control register blocks counting in that mode. The counter is a parameterised number of bits wide. When it wraps from all ones to zero, the block sets a sticky overflow flag. It raises a one-cycle interrupt request only if that flag was clear before the wrap, so the flag also serves as the interrupt disable.

Software reaches the counter and the control register through a plain single-cycle CSR port. A select input chooses between the two, and a write enable stores the 64-bit write data. The read data is combinational and shows the selected register. Event selection, interrupt routing and delegation belong to surrounding logic.

Top module: `pmc_counter`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0 and `ovf_irq_o` is low.
- R2: Each clock edge with `evt_i` high and counting not inhibited adds exactly 1 to the counter. With `evt_i` low and no counter write, the counter holds its value.
- R3: `mode_i` = {virtual, level[1:0]}. Level 2'b11 is machine mode whatever the virtual bit. Level 2'b01 is supervisor, or virtual supervisor when the virtual bit is set. Level 2'b00 is user, or virtual user when the virtual bit is set. Level 2'b10 is never inhibited. The inhibit bits sit in the control register at bit 62 (machine), 61 (supervisor), 60 (user), 59 (virtual supervisor) and 58 (virtual user). An event in a mode whose inhibit bit is set is not counted.
- R4: The inhibit bit of a mode the parameters mark as absent (`HAS_S`, `HAS_U`, `HAS_H` for both virtual modes) always reads 0, and writes to it have no effect, so events in that mode are counted.
- R5: The counter is `CNT_W` bits wide and reads zero-extended to 64 bits. An increment from all ones gives 0, and counting continues from there.
- R6: The overflow flag is bit 63 of the control register. Hardware sets it when the counter wraps, and it stays set until software writes the control register.
- R7: `ovf_irq_o` is high for exactly one cycle: the cycle in which the overflow flag first reads 1 after a wrap that happened while the flag was 0.
- R8: A wrap while the overflow flag is already 1 raises no request, and the flag stays 1.
- R9: Software writes never cause a wrap or a request. A counter write in the same cycle as an event stores the written value and drops the increment.
- R10: If a wrap and a control-register write occur in the same cycle, the flag ends at 1 whatever value was written. The request depends only on the flag's value before that edge.
- R11: `csr_sel_i` = 0 selects the counter and 1 selects the control register. Control bits 57:0 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Event increment pulse |
| mode_i | input | 3 | Current privilege mode {virtual, level} |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 1 | 0 selects counter, 1 selects control register |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | Read data of the selected register |
| ovf_irq_o | output | 1 | One-cycle overflow interrupt request |

## Verification
On every cycle the assertions check the following:
- The request appears only on the edge where the flag rises, and only after a genuine wrap.
- The flag stays set until a control write.
- A counter write lands exactly and raises no request.
- An idle or inhibited cycle leaves the count unchanged.
- An uninhibited event adds one, and a wrap returns the counter to zero.

Only the bench scenarios can show the following:
- The decoding of each of the six mode encodings against each inhibit bit.
- Read-only-zero inhibit bits in a build without user and virtual modes.
- Zero-extension of the read data.
- The outcome of a control write that collides with a wrap.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned N_MODES = 5;
  localparam int unsigned OF_POS  = 63;
  localparam int unsigned INH_LSB = 58;

  // index of each mode within the inhibit vector; bit INH_LSB+idx
  localparam int unsigned IDX_VU = 0;
  localparam int unsigned IDX_VS = 1;
  localparam int unsigned IDX_U  = 2;
  localparam int unsigned IDX_S  = 3;
  localparam int unsigned IDX_M  = 4;

  typedef enum logic [1:0] {
    LVL_U   = 2'b00,
    LVL_S   = 2'b01,
    LVL_RSV = 2'b10,
    LVL_M   = 2'b11
  } lvl_e;

  typedef logic [N_MODES-1:0] mode_vec_t;
endpackage

// File: rtl/pmc_mode_dec.sv
module pmc_mode_dec
  import pmc_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_vec_t  mode_oh_o
);
  logic virt;
  lvl_e lvl;

  assign virt = mode_i[2];
  assign lvl  = lvl_e'(mode_i[1:0]);

  always_comb begin
    mode_oh_o = '0;
    case (lvl)
      LVL_M: mode_oh_o[IDX_M] = 1'b1;
      LVL_S: begin
        if (virt) mode_oh_o[IDX_VS] = 1'b1;
        else      mode_oh_o[IDX_S]  = 1'b1;
      end
      LVL_U: begin
        if (virt) mode_oh_o[IDX_VU] = 1'b1;
        else      mode_oh_o[IDX_U]  = 1'b1;
      end
      default: mode_oh_o = '0;
    endcase
  end
endmodule

// File: rtl/pmc_inh_reg.sv
module pmc_inh_reg
  import pmc_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_H = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  mode_vec_t wr_data_i,
  output mode_vec_t inh_o
);
  localparam mode_vec_t IMPL = {1'b1, HAS_S, HAS_U, HAS_H, HAS_H};

  logic unused_wr_data;
  assign unused_wr_data = ^wr_data_i;

  for (genvar i = 0; i < N_MODES; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_q;
      logic bit_d;
      logic bit_en;

      always_comb begin
        bit_en = wr_en_i;
        bit_d  = wr_data_i[i];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end

      assign inh_o[i] = bit_q;
    end else begin : g_tied
      assign inh_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pmc_cnt_core.sv
module pmc_cnt_core #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] sum;
  logic             carry;
  logic             cnt_en;

  assign {carry, sum} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    cnt_en = wr_en_i | inc_i;
    if (wr_en_i) cnt_d = wr_data_i;
    else         cnt_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // wrap only from a hardware increment that is not overridden by a write
  assign wrap_o = inc_i & ~wr_en_i & carry;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pmc_ovf_ctl.sv
module pmc_ovf_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic wr_en_i,
  input  logic wr_of_i,
  output logic of_o,
  output logic irq_o
);
  logic of_q, of_d, of_en;
  logic irq_q, irq_d;

  always_comb begin
    of_en = wrap_i | wr_en_i;
    // a wrap wins over a software clear in the same cycle
    of_d  = wrap_i | wr_of_i;
    irq_d = wrap_i & ~of_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    of_q <= 1'b0;
    else if (of_en) of_q <= of_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign of_o  = of_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int unsigned CNT_W = 48,
  parameter bit          HAS_S = 1'b1,
  parameter bit          HAS_U = 1'b1,
  parameter bit          HAS_H = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic [2:0]      mode_i,
  input  logic            csr_we_i,
  input  logic            csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            ovf_irq_o
);
  localparam int unsigned PAD_W = XLEN - CNT_W;
  localparam int unsigned LOW_W = INH_LSB;

  mode_vec_t        mode_oh;
  mode_vec_t        inh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             of_q;
  logic             wrap;
  logic             cnt_wr;
  logic             ctl_wr;
  logic             count_en;
  logic             unused_wdata;

  assign unused_wdata = ^csr_wdata_i;

  assign cnt_wr   = csr_we_i & ~csr_sel_i;
  assign ctl_wr   = csr_we_i & csr_sel_i;
  assign count_en = evt_i & ~|(mode_oh & inh_q);

  pmc_mode_dec u_mode (
    .mode_i    (mode_i),
    .mode_oh_o (mode_oh)
  );

  pmc_inh_reg #(
    .HAS_S (HAS_S),
    .HAS_U (HAS_U),
    .HAS_H (HAS_H)
  ) u_inh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ctl_wr),
    .wr_data_i (csr_wdata_i[INH_LSB +: N_MODES]),
    .inh_o     (inh_q)
  );

  pmc_cnt_core #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (count_en),
    .wr_en_i   (cnt_wr),
    .wr_data_i (csr_wdata_i[CNT_W-1:0]),
    .cnt_o     (cnt_q),
    .wrap_o    (wrap)
  );

  pmc_ovf_ctl u_ovf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .wr_en_i (ctl_wr),
    .wr_of_i (csr_wdata_i[OF_POS]),
    .of_o    (of_q),
    .irq_o   (ovf_irq_o)
  );

  always_comb begin
    if (csr_sel_i) csr_rdata_o = {of_q, inh_q, {LOW_W{1'b0}}};
    else           csr_rdata_o = {{PAD_W{1'b0}}, cnt_q};
  end
endmodule

// File: rtl/pmc_counter_chk.sv
module pmc_counter_chk
  import pmc_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_i,
  input logic             csr_we_i,
  input logic             csr_sel_i,
  input logic [XLEN-1:0]  csr_wdata_i,
  input logic             ovf_irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             of_q,
  input mode_vec_t        inh_q,
  input mode_vec_t        mode_oh
);
  logic blocked;
  logic cwr;
  logic twr;
  assign blocked = |(mode_oh & inh_q);
  assign cwr     = csr_we_i & ~csr_sel_i;
  assign twr     = csr_we_i & csr_sel_i;

  // R7
  irq_onset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> (of_q && !$past(of_q)));

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> ($past(evt_i) && !$past(blocked) && !$past(cwr) && ($past(cnt_q) == {CNT_W{1'b1}})));

  // R6
  of_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_q && !twr) |=> of_q);

  // R9
  cnt_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr |=> ((cnt_q == $past(csr_wdata_i[CNT_W-1:0])) && !ovf_irq_o));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !cwr) |=> $stable(cnt_q));

  // R3
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && blocked && !cwr) |=> $stable(cnt_q));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !blocked && !cwr && (cnt_q != {CNT_W{1'b1}})) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !blocked && !cwr && (cnt_q == {CNT_W{1'b1}})) |=> ((cnt_q == '0) && of_q));
endmodule

bind pmc_counter pmc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .csr_we_i    (csr_we_i),
  .csr_sel_i   (csr_sel_i),
  .csr_wdata_i (csr_wdata_i),
  .ovf_irq_o   (ovf_irq_o),
  .cnt_q       (cnt_q),
  .of_q        (of_q),
  .inh_q       (inh_q),
  .mode_oh     (mode_oh)
);

// File: tb/sim_pmc_counter.sv
module sim_pmc_counter;
  localparam int    CLK_PERIOD = 10;
  localparam int    CW  = 48;
  localparam [63:0] MAX = (64'd1 << CW) - 64'd1;
  localparam [63:0] OFB = 64'h8000_0000_0000_0000;
  localparam [2:0]  M_M = 3'b011, M_S = 3'b001, M_U = 3'b000,
                    M_VS = 3'b101, M_VU = 3'b100, M_RSV = 3'b010, M_VM = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt;
  logic [2:0]  mode;
  logic        we;
  logic        sel;
  logic [63:0] wdata;
  logic [63:0] rdata, rdata1;
  logic        irq, irq1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_counter #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mode_i(mode),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .ovf_irq_o(irq));

  // reduced build: no user, no virtual modes
  pmc_counter #(.CNT_W(8), .HAS_S(1'b1), .HAS_U(1'b0), .HAS_H(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mode_i(mode),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata1), .ovf_irq_o(irq1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic s, output logic [63:0] v);
    we = 1'b0; sel = s; #1; v = rdata;
  endtask

  task automatic rd1(input logic s, output logic [63:0] v);
    we = 1'b0; sel = s; #1; v = rdata1;
  endtask

  task automatic wr(input logic s, input logic [63:0] d);
    evt = 1'b0; we = 1'b1; sel = s; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    evt = 1'b1; mode = m;
    for (int i = 0; i < n; i++) tick();
    evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(1'b0, v); chk("R1 counter", v, 64'd0);
    rd(1'b1, v); chk("R1 control", v, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_count();
    logic [63:0] v;
    wr(1'b1, 64'd0);
    wr(1'b0, 64'd5);
    pulse(M_M, 3);
    rd(1'b0, v); chk("R2 three events", v, 64'd8);
    tick(); tick();
    rd(1'b0, v); chk("R2 idle hold", v, 64'd8);
    evt = 1'b1; mode = M_S; tick(); evt = 1'b0; tick(); evt = 1'b1; tick(); evt = 1'b0;
    rd(1'b0, v); chk("R2 sparse events", v, 64'd10);
  endtask

  task automatic t_inhibit();
    logic [63:0] v;
    logic [2:0] md [5] = '{M_VU, M_VS, M_U, M_S, M_M};
    for (int i = 0; i < 5; i++) begin
      wr(1'b1, 64'd1 << (58 + i));
      wr(1'b0, 64'd0);
      pulse(md[i], 2);
      rd(1'b0, v); chk($sformatf("R3 inhibited mode %0d", i), v, 64'd0);
      pulse(md[(i + 1) % 5], 2);
      rd(1'b0, v); chk($sformatf("R3 other mode %0d", i), v, 64'd2);
    end
    wr(1'b1, 64'h7C00_0000_0000_0000);
    wr(1'b0, 64'd0);
    pulse(M_RSV, 3);
    rd(1'b0, v); chk("R3 reserved level counts", v, 64'd3);
    pulse(M_VM, 2);
    rd(1'b0, v); chk("R3 virt+machine is machine", v, 64'd3);
  endtask

  task automatic t_unimpl();
    logic [63:0] v;
    wr(1'b1, 64'h7C00_0000_0000_0000);
    rd1(1'b1, v); chk("R4 absent bits read zero", v, 64'h6000_0000_0000_0000);
    rd(1'b1, v);  chk("R4 full build keeps all", v, 64'h7C00_0000_0000_0000);
    wr(1'b0, 64'd0);
    pulse(M_U, 2);
    rd1(1'b0, v); chk("R4 user counts when absent", v, 64'd2);
    rd(1'b0, v);  chk("R3 user inhibited", v, 64'd0);
    pulse(M_VS, 1);
    rd1(1'b0, v); chk("R4 vs counts when absent", v, 64'd3);
    wr(1'b1, 64'd0);
  endtask

  task automatic t_wrap();
    logic [63:0] v;
    wr(1'b1, 64'd0);
    wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1'b0, v); chk("R5 zero-extended read", v, MAX);
    wr(1'b0, MAX - 64'd1);
    evt = 1'b1; mode = M_S;
    tick();
    rd(1'b0, v); chk("R5 reach all ones", v, MAX);
    chk("R7 no irq before wrap", {63'd0, irq}, 64'd0);
    tick();
    rd(1'b0, v); chk("R5 wrap to zero", v, 64'd0);
    chk("R7 irq on wrap", {63'd0, irq}, 64'd1);
    rd(1'b1, v); chk("R6 flag set", v, OFB);
    tick();
    evt = 1'b0;
    rd(1'b0, v); chk("R5 keeps counting", v, 64'd1);
    chk("R7 single-cycle pulse", {63'd0, irq}, 64'd0);
    tick();
    rd(1'b1, v); chk("R6 flag sticky", v, OFB);
  endtask

  task automatic t_of_held();
    logic [63:0] v;
    logic seen;
    wr(1'b0, MAX);
    evt = 1'b1; mode = M_M;
    tick();
    evt = 1'b0;
    seen = irq;
    rd(1'b0, v); chk("R8 wrap with flag set", v, 64'd0);
    chk("R8 no irq", {63'd0, seen}, 64'd0);
    rd(1'b1, v); chk("R8 flag still set", v, OFB);
    wr(1'b1, 64'd0);
    rd(1'b1, v); chk("R6 cleared by write", v, 64'd0);
  endtask

  task automatic t_sw_write();
    logic [63:0] v;
    wr(1'b0, MAX);
    chk("R9 write of all ones no irq", {63'd0, irq}, 64'd0);
    evt = 1'b1; mode = M_M; we = 1'b1; sel = 1'b0; wdata = 64'd7;
    tick();
    evt = 1'b0; we = 1'b0;
    chk("R9 collide no irq", {63'd0, irq}, 64'd0);
    rd(1'b0, v); chk("R9 write wins over increment", v, 64'd7);
    rd(1'b1, v); chk("R9 flag untouched", v, 64'd0);
    wr(1'b1, OFB);
    chk("R9 flag write no irq", {63'd0, irq}, 64'd0);
    wr(1'b1, 64'd0);
    chk("R9 flag clear no irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_race();
    logic [63:0] v;
    wr(1'b0, MAX);
    evt = 1'b1; mode = M_M; we = 1'b1; sel = 1'b1; wdata = 64'd0;
    tick();
    evt = 1'b0; we = 1'b0;
    chk("R10 irq on colliding wrap", {63'd0, irq}, 64'd1);
    rd(1'b1, v); chk("R10 flag survives clear", v, OFB);
    rd(1'b0, v); chk("R10 counter wrapped", v, 64'd0);
    wr(1'b1, 64'd0);
  endtask

  task automatic t_fields();
    logic [63:0] v;
    wr(1'b1, 64'h03FF_FFFF_FFFF_FFFF);
    rd(1'b1, v); chk("R11 low control bits read zero", v, 64'd0);
    wr(1'b0, 64'h0123_4567_89AB_CDEF);
    rd(1'b0, v); chk("R11 counter select", v, 64'h0000_4567_89AB_CDEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = 1'b0; mode = 3'b011; we = 1'b0; sel = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_count();
    t_inhibit();
    t_unimpl();
    t_wrap();
    t_of_held();
    t_sw_write();
    t_race();
    t_fields();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule